// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a slave-only I2C target that exposes a bank of 256 eight-bit control registers to an external host. It oversamples SCL and SDA with a fast system clock and passes both lines through two-flop synchronizers. It recognises start and stop conditions and answers only to the fixed 7-bit device address 0x40. The block drives SDA only as an open-drain pull-down enable, so the pad outside it sees a plain low-enable.

A write transfer carries a register pointer byte and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transfer has no pointer byte. It returns bytes starting at wherever the pointer was left, and the pointer again advances after every byte. A repeated start restarts address matching at once. The usual pattern is therefore to write the pointer, issue a repeated start, and then read.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After the synchronous reset, and whenever the slave is idle, `sda_oe` is 0, so SDA is released.
- R2: The slave acknowledges an address byte whose upper seven bits equal 7'b1000000, with either value of the direction bit. It acknowledges by holding `sda_oe` at 1 through the ninth SCL pulse.
- R3: The slave does not acknowledge an address byte with any other upper seven bits. It then ignores all bytes up to the next start condition, and the register contents and the pointer stay unchanged.
- R4: In a write transfer (direction bit 0), the first byte after the address loads the register pointer. Each following byte is stored at the pointer, and the pointer then increments by one. The slave acknowledges every one of these bytes.
- R5: In a read transfer (direction bit 1), the slave sends the register at the current pointer at once, with no pointer byte, most significant bit first.
- R6: After each byte the slave sends, the pointer increments. A master acknowledge (SDA low) makes the slave send the next register. A master not-acknowledge (SDA high) makes the slave release SDA and go idle.
- R7: The pointer wraps from 255 to 0, both on writes and on reads.
- R8: A start condition seen in the middle of a transfer, with no stop before it, restarts address matching while keeping the pointer.
- R9: The pointer persists across stop conditions. A new read continues after the last byte already read.
- R10: `sda_oe` changes only while SCL is low, and the block works at SCL periods of 124 system clock cycles, which is just above 400 kHz at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench drives a bus master model against a wired-AND SDA line at roughly 400 kHz. It targets the pointer-driven corners of the block. A read issued right after a write must start at the written pointer; a design that expected a pointer byte on reads would return the wrong registers. A burst that crosses address 255 must land at 0; a design with a wider or saturating pointer would store the byte elsewhere or overwrite 255. A foreign address must get no acknowledge and change nothing, whereas a design that kept decoding would corrupt register 0x10. A repeated start after the pointer byte must switch direction cleanly, and a master not-acknowledge must free SDA. A design that got either wrong would hold the line low and block the stop.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } rf_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchronizer flops plus one history flop per line
  logic [STAGES:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_prev = sda_pipe[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // single write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h40,
  parameter int         REG_AW    = 8,
  parameter int         DW        = 8,
  parameter int         SYNC_STGS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(DW);
  localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rf_state_e         state;
  logic [CW-1:0]     cnt;
  logic [DW-1:0]     shreg, txreg, rd_data;
  logic [REG_AW-1:0] ptr;
  logic              rw, nack;

  logic rx_state, byte_in, bus_evt, wr_en;
  assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDAT);
  assign byte_in  = (cnt == LAST_RX);
  assign bus_evt  = start_det | stop_det;
  assign wr_en    = scl_fall && !bus_evt && (state == ST_WDAT) && byte_in;

  i2c_reg_bank #(.AW(REG_AW), .DW(DW)) u_bank (
    .clk(clk), .we(wr_en), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (rx_state) begin
        shreg <= {shreg[DW-2:0], sda_lvl};
        cnt   <= cnt + 1'b1;
      end
      if (state == ST_RDAT_ACK) nack <= sda_lvl;
    end else if (scl_fall) begin
      case (state)
        ST_ADDR: if (byte_in) begin
          if (shreg[DW-1:1] == DEV_ADDR) begin
            rw     <= shreg[0];
            sda_oe <= 1'b1;
            state  <= ST_ADDR_ACK;
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          cnt <= '0;
          if (rw) begin
            txreg  <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            state  <= ST_RDAT;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_PTR;
          end
        end
        ST_PTR: if (byte_in) begin
          ptr    <= REG_AW'(shreg);
          sda_oe <= 1'b1;
          state  <= ST_PTR_ACK;
        end
        ST_WDAT: if (byte_in) begin
          ptr    <= ptr + 1'b1;
          sda_oe <= 1'b1;
          state  <= ST_WDAT_ACK;
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          state  <= ST_WDAT;
        end
        ST_RDAT: begin
          if (cnt == LAST_TX) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_RDAT_ACK;
          end else begin
            txreg  <= {txreg[DW-2:0], 1'b0};
            sda_oe <= ~txreg[DW-2];
            cnt    <= cnt + 1'b1;
          end
        end
        ST_RDAT_ACK: begin
          if (nack) begin
            state <= ST_IDLE;
          end else begin
            txreg  <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            cnt    <= '0;
            state  <= ST_RDAT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int         REG_AW   = 8,
  parameter int         DW       = 8,
  parameter int         CW       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input rf_state_e         state,
  input logic [CW-1:0]     cnt,
  input logic [DW-1:0]     shreg,
  input logic              wr_en,
  input logic [REG_AW-1:0] ptr
);
  logic addr_done;
  assign addr_done = scl_fall && !start_det && !stop_det &&
                     (state == ST_ADDR) && (cnt == CW'(DW));

  // R1: idle means SDA released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: matching address is acknowledged
  p_match_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_done && shreg[DW-1:1] == DEV_ADDR) |=> (sda_oe && state == ST_ADDR_ACK));

  // R3: foreign address leaves the slave idle and silent
  p_foreign_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_done && shreg[DW-1:1] != DEV_ADDR) |=> (!sda_oe && state == ST_IDLE));

  // R4 / R7: pointer steps by one (modulo) after each stored byte
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr == $past(ptr) + 1'b1));

  // R8: any start returns to address matching with SDA released
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe && $stable(ptr)));

  // R10: SDA drive only moves while SCL is low
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl) && !start_det && !stop_det) |-> $stable(sda_oe));
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(
  .DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .state(state), .cnt(cnt), .shreg(shreg), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;
  localparam int Q = 31; // quarter SCL period in clocks: 124-clock SCL

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #10 clk = ~clk; // 50 MHz

  assign sda_line = sda_m & ~sda_oe;

  i2c_regfile_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  int hold_viol = 0;
  logic finished = 1'b0;

  // R10 monitor: drive must not move while raw SCL stays high
  logic scl_d = 1'b1, oe_d = 1'b0;
  always @(posedge clk) begin
    if (!rst && scl_m && scl_d && (sda_oe !== oe_d)) hold_viol++;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    ack = ~sda_line; q();
    scl_m = 1'b0; q();
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      d[i] = sda_line; q();
      scl_m = 1'b0; q();
    end
    sda_m = ~master_ack; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic t_reset();
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_write_burst();
    logic a;
    logic [7:0] dat [6] = '{8'h5A, 8'hC3, 8'h01, 8'hFE, 8'h77, 8'h3C};
    bus_start();
    put_byte(8'h80, a); chk("R2 write address ack", {31'd0, a}, 32'd1);
    put_byte(8'h10, a); chk("R4 pointer byte ack", {31'd0, a}, 32'd1);
    for (int i = 0; i < 6; i++) begin
      put_byte(dat[i], a); chk("R4 data byte ack", {31'd0, a}, 32'd1);
    end
    bus_stop();
    chk("R1 idle after stop", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_read_from_pointer();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h80, a);
    put_byte(8'h10, a);
    bus_stop();
    bus_start();
    put_byte(8'h81, a); chk("R2 read address ack", {31'd0, a}, 32'd1);
    get_byte(1'b1, d); chk("R5 first byte at pointer", {24'd0, d}, 32'h5A);
    get_byte(1'b1, d); chk("R6 second byte", {24'd0, d}, 32'hC3);
    get_byte(1'b1, d); chk("R6 third byte", {24'd0, d}, 32'h01);
    get_byte(1'b0, d); chk("R6 last byte", {24'd0, d}, 32'hFE);
    chk("R6 released after nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();
  endtask

  task automatic t_pointer_persists();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h81, a);
    get_byte(1'b1, d); chk("R9 continue read", {24'd0, d}, 32'h77);
    get_byte(1'b0, d); chk("R9 continue read", {24'd0, d}, 32'h3C);
    bus_stop();
  endtask

  task automatic t_bad_address();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h82, a); chk("R3 foreign address nack", {31'd0, a}, 32'd0);
    put_byte(8'h10, a); chk("R3 ignored byte nack", {31'd0, a}, 32'd0);
    put_byte(8'h99, a); chk("R3 ignored byte nack", {31'd0, a}, 32'd0);
    bus_stop();
    bus_start();
    put_byte(8'h80, a);
    put_byte(8'h10, a);
    bus_stop();
    bus_start();
    put_byte(8'h81, a);
    get_byte(1'b0, d); chk("R3 register unchanged", {24'd0, d}, 32'h5A);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h80, a);
    put_byte(8'hFE, a);
    put_byte(8'hA1, a);
    put_byte(8'hB2, a);
    put_byte(8'hC7, a); chk("R7 ack after wrap", {31'd0, a}, 32'd1);
    bus_stop();
    bus_start();
    put_byte(8'h80, a);
    put_byte(8'hFE, a);
    bus_stop();
    bus_start();
    put_byte(8'h81, a);
    get_byte(1'b1, d); chk("R7 reg 0xFE", {24'd0, d}, 32'hA1);
    get_byte(1'b1, d); chk("R7 reg 0xFF", {24'd0, d}, 32'hB2);
    get_byte(1'b0, d); chk("R7 reg 0x00 after wrap", {24'd0, d}, 32'hC7);
    bus_stop();
  endtask

  task automatic t_repeated_start();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h80, a);
    put_byte(8'h11, a);
    bus_start();
    put_byte(8'h81, a); chk("R8 address ack after restart", {31'd0, a}, 32'd1);
    get_byte(1'b1, d); chk("R8 read at new pointer", {24'd0, d}, 32'hC3);
    get_byte(1'b0, d); chk("R8 next byte", {24'd0, d}, 32'h01);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_from_pointer();
    t_pointer_persists();
    t_bad_address();
    t_wrap();
    t_repeated_start();
    chk("R10 sda stable while scl high", hold_viol, 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule